// File: doc/BRIEF.md
# Phase-Offset PWM Bank

A bank of PWM outputs that all run from one shared counter. A programmable prescaler divides the system clock to set the counter rate, so every output has the same period. Each channel places its rising edge and falling edge anywhere inside the counter cycle, which gives it both a duty cycle and a phase offset. Two override flags per channel force the output fully on or fully off. FULL_OFF always wins over FULL_ON.

Software writes byte-wide registers through a synchronous write port. Channel writes land in shadow registers. They move into the live compare registers only at the channel's own commit point, which is the counter value at which the channel's low phase ends. This means a new setting never cuts short or stretches the cycle that is running. Two commit modes exist. In immediate mode every byte write is eligible at the next commit point. In wait-for-four mode nothing commits until all four bytes of the channel have been written.

A sleep control stops the time base and drives every output to the inactive level. A global invert flag selects that level. The prescaler can only be written while asleep. A restart pulse brings channels back with their earlier waveforms after a wake-up. A write to the all-channel address range reaches every channel's shadow at once.

Top module: `pwm_phase_bank`

## Requirements
- R1: The prescaler value p makes the shared counter advance once every p+1 clocks. All channels therefore share one period of (p+1)*2^CNT_W clocks.
- R2: A channel is active while the counter is in [ON, OFF). When OFF < ON the window wraps through the counter's end. When ON equals OFF the channel is never active.
- R3: Live ON/OFF/flag values change only on a clock where the counter equals the live ON value. The shadow contents become live there, and the output at that count already follows them.
- R4: Channel n occupies addresses 0x08+4n: +0 ON low byte, +1 ON high bits (bits 3:0), +2 OFF low byte, +3 OFF high bits (bits 3:0). In immediate mode (control bit 2 clear) each byte write commits at the next commit point on its own. A low byte written without its high byte can therefore be live for a whole cycle.
- R5: With control bit 2 set, a channel commits only after its four bytes have all been written since its last commit.
- R6: FULL_OFF is bit 4 of the OFF high register. When it is set, the output is inactive regardless of FULL_ON and the counts. Clearing it brings back the programmed waveform unchanged.
- R7: FULL_ON is bit 4 of the ON high register. When it is set and FULL_OFF is clear, the output is constantly active.
- R8: While control bit 0 (sleep) is set, every output sits at the inactive level and the counter is held at zero.
- R9: Control bit 1 inverts all outputs. The inactive level is then high, and the active phase is driven low.
- R10: The prescaler register at 0x01 accepts writes only while asleep; writes made while awake are ignored. A new prescaler scales every pulse width and phase, and leaves each channel's ratio unchanged.
- R11: Setting sleep parks every channel at the inactive level. After wake-up a control write with bit 3 set (and bit 0 clear) resumes all channels with their previous live settings. A commit on a parked channel un-parks only that channel.
- R12: Writes to 0xF0..0xF3 (same byte order as R4) load the shadow registers of every channel, with the same commit timing as a per-channel write.
- R13: After reset the block is asleep, not inverted, in immediate mode, with prescaler 0. Every channel has FULL_OFF set, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | NUM_CH | Channel outputs, after invert |

## Verification
The embedded assertions check the following on every cycle:
- The counter moves by at most one step.
- Live settings change only at the channel's commit count.
- A channel with FULL_OFF live and nothing pending sits at the inactive level.
- Parked and sleeping channels stay inactive.
- Fewer than four bytes never make a commit pending in wait-for-four mode.
- The prescaler cannot change while awake.

Some behaviour only the bench scenarios can show, because it needs whole periods to observe:
- Measured pulse widths, periods and phases across a sweep of ON/OFF pairs.
- The one-cycle mismatched-byte hazard.
- Restoration after FULL_OFF is cleared.
- Resumption after restart.
- Scaling by the prescaler.

// File: rtl/pwmbank_pkg.sv
`timescale 1ns/1ps
package pwmbank_pkg;
  localparam int unsigned MAX_CNT_W = 12;
  localparam logic [7:0]  A_CTRL     = 8'h00;
  localparam logic [7:0]  A_PRESC    = 8'h01;
  localparam logic [7:0]  A_CH_BASE  = 8'h08;
  localparam logic [7:0]  A_ALL_BASE = 8'hF0;
  localparam int unsigned CB_SLEEP   = 0;
  localparam int unsigned CB_INV     = 1;
  localparam int unsigned CB_WAITALL = 2;
  localparam int unsigned CB_RESTART = 3;
  localparam int unsigned FLAG_BIT   = 4;

  typedef logic [MAX_CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t on;
    cnt_t off;
    logic full_on;
    logic full_off;
  } chcfg_t;

  localparam chcfg_t CFG_RST = '{on: '0, off: '0, full_on: 1'b0, full_off: 1'b1};

  // active window [on, off), wrapping when off < on
  function automatic logic in_window(cnt_t c, cnt_t on, cnt_t off);
    if (on <= off) return (c >= on) && (c < off);
    else           return (c >= on) || (c < off);
  endfunction
endpackage

// File: rtl/pwmbank_timebase.sv
`timescale 1ns/1ps
module pwmbank_timebase #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  logic [PRE_W-1:0] presc,
  output logic [CNT_W-1:0] cnt
);
  logic [PRE_W-1:0] pre_q, pre_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    pre_n = pre_q;
    cnt_n = cnt_q;
    if (sleep) begin
      pre_n = '0;
      cnt_n = '0;
    end else if (pre_q == presc) begin
      pre_n = '0;
      cnt_n = cnt_q + 1'b1;
    end else begin
      pre_n = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_n;
      cnt_q <= cnt_n;
    end
  end

  assign cnt = cnt_q;

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwmbank_regs.sv
`timescale 1ns/1ps
module pwmbank_regs
  import pwmbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned PRE_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic                  sleep,
  output logic                  invert,
  output logic                  wait_all,
  output logic                  restart_p,
  output logic                  sleep_enter_p,
  output logic [PRE_W-1:0]      presc,
  output logic [NUM_CH*4-1:0]   byte_we
);
  logic             sleep_q, sleep_n;
  logic             inv_q, inv_n;
  logic             wait_q, wait_n;
  logic [PRE_W-1:0] presc_q, presc_n;
  logic             ctrl_hit, presc_hit, all_hit;

  assign ctrl_hit  = wr_en && (wr_addr == A_CTRL);
  assign presc_hit = wr_en && (wr_addr == A_PRESC);
  assign all_hit   = wr_en && (wr_addr[7:2] == A_ALL_BASE[7:2]);

  always_comb begin
    sleep_n = sleep_q;
    inv_n   = inv_q;
    wait_n  = wait_q;
    presc_n = presc_q;
    if (ctrl_hit) begin
      sleep_n = wr_data[CB_SLEEP];
      inv_n   = wr_data[CB_INV];
      wait_n  = wr_data[CB_WAITALL];
    end
    if (presc_hit && sleep_q) presc_n = wr_data[PRE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b1;
      inv_q   <= 1'b0;
      wait_q  <= 1'b0;
      presc_q <= '0;
    end else begin
      if (ctrl_hit) begin
        sleep_q <= sleep_n;
        inv_q   <= inv_n;
        wait_q  <= wait_n;
      end
      if (presc_hit) presc_q <= presc_n;
    end
  end

  assign restart_p     = ctrl_hit && wr_data[CB_RESTART] && !wr_data[CB_SLEEP];
  assign sleep_enter_p = ctrl_hit && wr_data[CB_SLEEP] && !sleep_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam logic [5:0] SLOT = 6'((int'(A_CH_BASE) >> 2) + c);
    logic ch_hit;
    assign ch_hit = wr_en && (wr_addr[7:2] == SLOT);
    assign byte_we[c*4 +: 4] = (ch_hit || all_hit) ? (4'b0001 << wr_addr[1:0]) : 4'b0000;
  end

  assign sleep    = sleep_q;
  assign invert   = inv_q;
  assign wait_all = wait_q;
  assign presc    = presc_q;

  // R10
  presc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_q |=> $stable(presc_q));
endmodule

// File: rtl/pwmbank_chan.sv
`timescale 1ns/1ps
module pwmbank_chan
  import pwmbank_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             sleep,
  input  logic             invert,
  input  logic             wait_all,
  input  logic             restart_p,
  input  logic             sleep_enter_p,
  input  logic [3:0]       byte_we,
  input  logic [7:0]       wr_data,
  output logic             pwm
);
  localparam int unsigned HI_W    = CNT_W - 8;
  localparam logic [3:0]  HI_MASK = 4'((1 << HI_W) - 1);

  chcfg_t     sh_q, sh_n, lv_q, eff;
  logic [3:0] mask_q, mask_n;
  logic       pend_q, pend_n;
  logic       park_q, park_n;
  logic       pwm_q, pwm_n;
  logic       commit, lvl;
  cnt_t       cnt_x;

  assign cnt_x  = cnt_t'(cnt);
  assign commit = pend_q && (lv_q.on == cnt_x) && !sleep;
  assign eff    = commit ? sh_q : lv_q;

  always_comb begin
    sh_n = sh_q;
    if (byte_we[0]) sh_n.on[7:0] = wr_data;
    if (byte_we[1]) begin
      sh_n.on[11:8] = wr_data[3:0] & HI_MASK;
      sh_n.full_on  = wr_data[FLAG_BIT];
    end
    if (byte_we[2]) sh_n.off[7:0] = wr_data;
    if (byte_we[3]) begin
      sh_n.off[11:8] = wr_data[3:0] & HI_MASK;
      sh_n.full_off  = wr_data[FLAG_BIT];
    end
  end

  always_comb begin
    mask_n = mask_q;
    pend_n = pend_q && !commit;
    if (|byte_we) begin
      if (wait_all) begin
        if ((mask_q | byte_we) == 4'hF) begin
          pend_n = 1'b1;
          mask_n = 4'h0;
        end else begin
          mask_n = mask_q | byte_we;
        end
      end else begin
        pend_n = 1'b1;
        mask_n = 4'h0;
      end
    end
  end

  always_comb begin
    park_n = park_q;
    if (sleep_enter_p)            park_n = 1'b1;
    else if (restart_p || commit) park_n = 1'b0;
  end

  always_comb begin
    lvl = !sleep && !(park_q && !commit) && !eff.full_off &&
          (eff.full_on || in_window(cnt_x, eff.on, eff.off));
    pwm_n = lvl ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= CFG_RST;
      lv_q   <= CFG_RST;
      mask_q <= 4'h0;
      pend_q <= 1'b0;
      park_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (|byte_we) sh_q <= sh_n;
      if (commit)   lv_q <= sh_q;
      mask_q <= mask_n;
      pend_q <= pend_n;
      park_q <= park_n;
      pwm_q  <= pwm_n;
    end
  end

  assign pwm = pwm_q;

  // R3
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_q.on != cnt_x) |=> $stable(lv_q));
  // R6
  full_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_q.full_off && !pend_q) |=> (pwm_q == $past(invert)));
  // R5
  four_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_all && !pend_q && $countones(mask_q) < 3) |=> !pend_q);
  // R11
  park_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (park_q && !pend_q) |=> (pwm_q == $past(invert)));
endmodule

// File: rtl/pwm_phase_bank.sv
`timescale 1ns/1ps
module pwm_phase_bank #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                slp, inv, wall, rst_p, slp_p;
  logic [PRE_W-1:0]    presc;
  logic [CNT_W-1:0]    cnt;
  logic [NUM_CH*4-1:0] bwe;

  pwmbank_regs #(.NUM_CH(NUM_CH), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sleep(slp), .invert(inv), .wait_all(wall), .restart_p(rst_p),
    .sleep_enter_p(slp_p), .presc(presc), .byte_we(bwe));

  pwmbank_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .sleep(slp), .presc(presc), .cnt(cnt));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmbank_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .sleep(slp), .invert(inv),
      .wait_all(wall), .restart_p(rst_p), .sleep_enter_p(slp_p),
      .byte_we(bwe[c*4 +: 4]), .wr_data(wr_data), .pwm(pwm_out[c]));
  end

  // R8
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slp |=> (pwm_out == ($past(inv) ? {NUM_CH{1'b1}} : {NUM_CH{1'b0}})));
endmodule

// File: tb/pwm_phase_bank_tb.sv
`timescale 1ns/1ps
module pwm_phase_bank_tb;
  localparam int NCH = 4;
  localparam int CW  = 9;
  localparam int PW  = 8;
  localparam int CR  = 1 << CW;

  logic clk, rst_n, wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [NCH-1:0] pwm_out;

  pwm_phase_bank #(.NUM_CH(NCH), .CNT_W(CW), .PRE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic inv_b = 1'b0;
  int pnow = CR;
  int presc_b = 0;
  int rise_cnt[NCH], last_rise[NCH], prev_rise[NCH], last_fall[NCH];
  logic prev_lv[NCH];

  initial begin
    for (int i = 0; i < NCH; i++) begin
      rise_cnt[i] = 0; last_rise[i] = 0; prev_rise[i] = 0; last_fall[i] = 0; prev_lv[i] = 1'b0;
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < NCH; i++) begin
      logic lv;
      lv = pwm_out[i] ^ inv_b;
      if (lv && !prev_lv[i]) begin
        prev_rise[i] = last_rise[i];
        last_rise[i] = cyc;
        rise_cnt[i]  = rise_cnt[i] + 1;
      end
      if (!lv && prev_lv[i]) last_fall[i] = cyc;
      prev_lv[i] = lv;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check_eq(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic set_at(logic [7:0] base, int on, int off, bit fon, bit foff);
    wr(base,        8'(on & 255));
    wr(base + 8'd1, {3'b000, fon, 4'(on >> 8)});
    wr(base + 8'd2, 8'(off & 255));
    wr(base + 8'd3, {3'b000, foff, 4'(off >> 8)});
  endtask

  function automatic logic [7:0] chb(int ch);
    return 8'(8 + 4 * ch);
  endfunction

  task automatic measure(int ch, output int width, output int per, output int phase);
    int r0, t;
    r0 = rise_cnt[ch]; t = 0;
    width = -1; per = -1; phase = -1;
    while (rise_cnt[ch] < r0 + 2 && t < 3 * pnow + 64) begin
      @(negedge clk); #1; t++;
    end
    if (rise_cnt[ch] >= r0 + 2) begin
      per   = last_rise[ch] - prev_rise[ch];
      width = last_fall[ch] - prev_rise[ch];
      phase = (((last_rise[ch] - last_rise[0]) % per) + per) % per;
    end
  endtask

  task automatic hold_level(int ch, logic lvl, int n, string tag, string what);
    int bad;
    bad = 0;
    repeat (n) begin
      @(negedge clk); #1;
      if (pwm_out[ch] !== (lvl ^ inv_b)) bad++;
    end
    check_eq(tag, what, bad, 0);
  endtask

  task automatic hold_all(logic [NCH-1:0] pat, int n, string tag, string what);
    int bad;
    bad = 0;
    repeat (n) begin
      @(negedge clk); #1;
      if (pwm_out !== pat) bad++;
    end
    check_eq(tag, what, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int w, p, ph, ew;
    int ons[5];
    int offs[5];
    ons  = '{0, 1, 100, 300, 511};
    offs = '{0, 5, 256, 400, 511};
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    wait_cyc(5);
    rst_n = 1'b1;
    // R13 reset: asleep, outputs low
    hold_all('0, 16, "R13", "outputs after reset");
    wr(8'h00, 8'h00);
    hold_all('0, 2 * pnow, "R13", "outputs after wake, FULL_OFF default");

    // reference channel 0: on=0 off=256
    set_at(chb(0), 0, 256, 1'b0, 1'b0);
    wait_cyc(2 * pnow);
    measure(0, w, p, ph);
    check_eq("R1", "ch0 period", p, CR);
    check_eq("R2", "ch0 width", w, 256);

    // R2 sweep of ON/OFF on channel 1
    foreach (ons[i]) begin
      foreach (offs[j]) begin
        set_at(chb(1), ons[i], offs[j], 1'b0, 1'b0);
        wait_cyc(2 * pnow);
        if (ons[i] == offs[j]) begin
          hold_level(1, 1'b0, pnow + 8, "R2", "equal ON/OFF stays inactive");
        end else begin
          ew = (ons[i] < offs[j]) ? offs[j] - ons[i] : CR - ons[i] + offs[j];
          measure(1, w, p, ph);
          check_eq("R2", "sweep width", w, ew);
          check_eq("R1", "sweep period", p, CR);
          check_eq("R2", "sweep phase", ph, ons[i]);
        end
      end
    end

    // R4 immediate-mode hazard on channel 2
    set_at(chb(2), 'h0F0, 'h1F0, 1'b0, 1'b0);
    wait_cyc(2 * pnow);
    measure(2, w, p, ph);
    check_eq("R3", "ch2 phase before update", ph, 'h0F0);
    wr(chb(2), 8'h10);
    wait_cyc(pnow + 16);
    measure(2, w, p, ph);
    check_eq("R4", "mismatched ON phase", ph, 'h010);
    check_eq("R4", "mismatched width", w, 'h1E0);
    wr(chb(2) + 8'd1, 8'h01);
    wait_cyc(2 * pnow);
    measure(2, w, p, ph);
    check_eq("R4", "completed ON phase", ph, 'h110);
    check_eq("R3", "completed width", w, 'h0E0);

    // R5 wait-for-four mode
    wr(8'h00, 8'h04);
    wr(chb(2), 8'h80);
    wait_cyc(2 * pnow);
    measure(2, w, p, ph);
    check_eq("R5", "partial write held back", ph, 'h110);
    wr(chb(2) + 8'd1, 8'h00);
    wr(chb(2) + 8'd2, 8'hF0);
    wr(chb(2) + 8'd3, 8'h01);
    wait_cyc(2 * pnow);
    measure(2, w, p, ph);
    check_eq("R5", "four-byte phase", ph, 'h080);
    check_eq("R5", "four-byte width", w, 'h170);
    wr(8'h00, 8'h00);

    // R6 / R7 override flags on channel 3
    set_at(chb(3), 'h020, 'h0A0, 1'b0, 1'b0);
    wait_cyc(2 * pnow);
    measure(3, w, p, ph);
    check_eq("R2", "ch3 width", w, 'h080);
    wr(chb(3) + 8'd1, 8'h10);
    wait_cyc(2 * pnow);
    hold_level(3, 1'b1, pnow, "R7", "FULL_ON constant active");
    wr(chb(3) + 8'd3, 8'h10);
    wait_cyc(2 * pnow);
    hold_level(3, 1'b0, pnow, "R6", "FULL_OFF beats FULL_ON");
    wr(chb(3) + 8'd1, 8'h00);
    wait_cyc(2 * pnow);
    hold_level(3, 1'b0, pnow, "R6", "FULL_OFF alone inactive");
    wr(chb(3) + 8'd3, 8'h00);
    wait_cyc(2 * pnow);
    measure(3, w, p, ph);
    check_eq("R6", "restored width", w, 'h080);
    check_eq("R6", "restored phase", ph, 'h020);

    // R9 invert
    set_at(chb(1), 100, 356, 1'b0, 1'b0);
    wait_cyc(2 * pnow);
    wr(8'h00, 8'h02); inv_b = 1'b1;
    wait_cyc(pnow);
    measure(1, w, p, ph);
    check_eq("R9", "inverted active width", w, 256);
    wr(chb(3) + 8'd3, 8'h10);
    wait_cyc(2 * pnow);
    hold_all(4'b1000 & {NCH{pwm_out[3]}}, 0, "R9", "noop");
    hold_level(3, 1'b0, pnow, "R9", "inactive level high under invert");

    // R10 prescaler ignored while awake
    wr(8'h01, 8'h03);
    wait_cyc(pnow);
    measure(1, w, p, ph);
    check_eq("R10", "awake prescaler write ignored", p, CR);

    // R8 sleep
    wr(8'h00, 8'h03);
    wait_cyc(4);
    hold_all('1, pnow, "R8", "sleep with invert drives high");
    wr(8'h00, 8'h01); inv_b = 1'b0;
    wait_cyc(4);
    hold_all('0, 64, "R8", "sleep drives low");

    // R10 prescaler accepted while asleep
    wr(8'h01, 8'h01); presc_b = 1; pnow = CR * 2;

    // R11 wake without restart: parked
    wr(8'h00, 8'h00);
    hold_all('0, 2 * pnow, "R11", "parked after plain wake");
    set_at(chb(2), 0, 'h100, 1'b0, 1'b0);
    wait_cyc(2 * pnow);
    measure(2, w, p, ph);
    check_eq("R11", "commit un-parks ch2 width", w, 'h100 * 2);
    check_eq("R10", "scaled period", p, pnow);
    hold_level(1, 1'b0, pnow, "R11", "ch1 still parked");
    wr(8'h00, 8'h08);
    wait_cyc(2 * pnow);
    measure(1, w, p, ph);
    check_eq("R11", "restart resumes ch1 width", w, 512);
    check_eq("R10", "ratio kept, phase scaled", ph, 200);

    // R12 broadcast
    set_at(8'hF0, 'h040, 'h0C0, 1'b0, 1'b0);
    wait_cyc(2 * pnow);
    for (int c = 1; c < NCH; c++) begin
      measure(c, w, p, ph);
      check_eq("R12", "broadcast width", w, 256);
      check_eq("R1", "shared period", p, pnow);
      check_eq("R12", "broadcast phase", ph, 0);
    end

    summary();
    $finish;
  end
endmodule